// File: doc/BRIEF.md
# Matrix row-group clear sequencer

This block takes one 32-bit zeroing instruction for a square accumulator array and turns it into a stream of row indices to clear. The array has one row for every 8 bytes of the current vector length. The array is split into 1, 2 or 4 equal partitions. In each partition the block clears one aligned pair of adjacent rows. The pair's position comes from an index register value plus a small scaled immediate, taken modulo the partition size.

A request is a single valid/ready beat. It carries the instruction word, a feature-enable bit, the 32-bit index register value and the vector length in bytes. The block also exposes which index register the word names, so the register file read can be wired to it. A request is taken only while the block is idle.

A word that decodes badly, or arrives with the feature disabled or an unusable vector length, raises a one-cycle undefined pulse and clears nothing. A good word produces 2, 4 or 8 row beats on a valid/ready output stream, followed by a one-cycle done pulse. Output back-pressure is honoured: a row beat holds until it is accepted.

Top module: `zgrp_clear_seq`

## Requirements
- R1: A word is well formed only when bits 31..18 equal 11000000000011, bit 17 is 0 and bits 12..3 are all 0. Any other word raises `undef` and emits no rows.
- R2: Bits 16..15 select the partition count: 01 gives one, 10 gives two and 11 gives four. The value 00 is undefined. For two and four partitions, bit 2 set is undefined.
- R3: When `req_feat_en` is low, an accepted request raises `undef` and emits no rows.
- R4: `req_vl_bytes` must be a power of two from 16 to 256, and the partition stride (row count / partition count) must be at least 2. Otherwise the request is undefined.
- R5: `idx_reg_num` equals 8 plus bits 14..13 of `req_insn`, so its value lies between 8 and 11.
- R6: The immediate is twice bits 2..0 for one partition, and twice bits 1..0 for two or four partitions.
- R7: The first row is ((index value + immediate) mod stride) rounded down to an even number. Row count = VL bytes / 8, and stride = row count / partition count.
- R8: Rows come out in this order: start, start+1, then the same pair advanced by one stride, and so on for each partition. That gives 2, 4 or 8 beats in total.
- R9: While `clr_valid` is high and `clr_ready` is low, `clr_row` and `clr_valid` hold.
- R10: `undef` pulses for one cycle, one cycle after a bad request is accepted. `done` pulses for one cycle, one cycle after the final row handshake. The two never pulse together.
- R11: `req_ready` is low while rows are being issued, and a request offered then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_insn | input | 32 | Instruction word |
| req_feat_en | input | 1 | Feature enable |
| req_idx_val | input | 32 | Value of the named index register |
| req_vl_bytes | input | 9 | Vector length in bytes |
| idx_reg_num | output | 4 | Index register number named by `req_insn` |
| busy | output | 1 | Row beats outstanding |
| clr_valid | output | 1 | Row beat valid |
| clr_ready | input | 1 | Row beat accepted by consumer |
| clr_row | output | 5 | Row index to clear |
| done | output | 1 | Pulse after last row |
| undef | output | 1 | Pulse for an undefined request |

## Verification
The undefined pulse appears in the cycle after the accepting edge. For a good request, the first row beat is valid in that same following cycle. Each later beat appears in the cycle after the previous handshake, and `done` appears in the cycle after the last handshake. The bench drives inputs and samples outputs at the falling edge, so each check reads exactly the cycle in which its result is due. It throttles `clr_ready` at random, so a stalled beat is checked again unchanged in the next cycle.

// File: rtl/zgrp_pkg.sv
package zgrp_pkg;
  localparam logic [13:0] OPC_HI = 14'b11000000000011;

  typedef enum logic [1:0] {
    GSEL_NONE = 2'b00,
    GSEL_ONE  = 2'b01,
    GSEL_TWO  = 2'b10,
    GSEL_FOUR = 2'b11
  } gsel_e;
endpackage

// File: rtl/zgrp_decode.sv
module zgrp_decode
  import zgrp_pkg::*;
#(
  parameter int VL_W       = 9,
  parameter int MIN_VL_LOG = 4,
  parameter int MAX_VL_LOG = 8,
  parameter int LOG_W      = 4
) (
  input  logic [31:0]      insn,
  input  logic             feat_en,
  input  logic [VL_W-1:0]  vl,
  output logic             ok,
  output logic [1:0]       ngrp_log,
  output logic [3:0]       imm,
  output logic [LOG_W-1:0] stride_log,
  output logic [3:0]       reg_num
);
  logic             fixed_ok, form_ok, vl_pow2, vl_range_ok, stride_ok;
  logic [LOG_W-1:0] vl_log, rows_log;

  assign reg_num = {2'b10, insn[14:13]};

  always_comb begin
    fixed_ok = (insn[31:18] == OPC_HI) && !insn[17] && (insn[12:3] == 10'd0);
    ngrp_log = 2'd0;
    imm      = 4'd0;
    form_ok  = 1'b0;
    case (gsel_e'(insn[16:15]))
      GSEL_ONE:  begin ngrp_log = 2'd0; imm = {insn[2:0], 1'b0};       form_ok = 1'b1;     end
      GSEL_TWO:  begin ngrp_log = 2'd1; imm = {1'b0, insn[1:0], 1'b0}; form_ok = !insn[2]; end
      GSEL_FOUR: begin ngrp_log = 2'd2; imm = {1'b0, insn[1:0], 1'b0}; form_ok = !insn[2]; end
      default:   begin ngrp_log = 2'd0; imm = 4'd0;                    form_ok = 1'b0;     end
    endcase
  end

  always_comb begin
    vl_log = '0;
    for (int i = 0; i < VL_W; i++)
      if (vl[i]) vl_log = LOG_W'(i);
  end

  assign vl_pow2     = (vl != '0) && ((vl & (vl - VL_W'(1))) == '0);
  assign vl_range_ok = (vl_log >= LOG_W'(MIN_VL_LOG)) && (vl_log <= LOG_W'(MAX_VL_LOG));
  assign rows_log    = vl_log - LOG_W'(3);
  assign stride_ok   = rows_log > LOG_W'(ngrp_log);
  assign stride_log  = rows_log - LOG_W'(ngrp_log);
  assign ok          = feat_en && fixed_ok && form_ok && vl_pow2 && vl_range_ok && stride_ok;
endmodule

// File: rtl/zgrp_rowgen.sv
module zgrp_rowgen #(
  parameter int ROW_W = 5,
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] start_row,
  input  logic [LOG_W-1:0] stride_log,
  input  logic [1:0]       ngrp_log,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row,
  output logic             last_fire
);
  logic             active;
  logic [ROW_W-1:0] base;
  logic [LOG_W-1:0] s_log;
  logic [1:0]       g_log;
  logic [2:0]       k;
  logic [2:0]       k_last;
  logic             fire;

  assign k_last    = 3'((4'd2 << g_log) - 4'd1);
  assign fire      = active && out_ready;
  assign last_fire = fire && (k == k_last);
  assign out_valid = active;
  assign out_row   = base + (ROW_W'(k[2:1]) << s_log) + ROW_W'(k[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      s_log  <= '0;
      g_log  <= '0;
      k      <= '0;
    end else if (load) begin
      active <= 1'b1;
      base   <= start_row;
      s_log  <= stride_log;
      g_log  <= ngrp_log;
      k      <= '0;
    end else if (fire) begin
      if (k == k_last) active <= 1'b0;
      else             k      <= k + 3'd1;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R11
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row)); // R9
  AST_PAIR_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !k[0] |=> out_valid && out_row == $past(out_row) + ROW_W'(1)); // R8
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ROW_W + 1)'(out_row) < ((ROW_W + 1)'(1) << (s_log + LOG_W'(g_log)))); // R7
endmodule

// File: rtl/zgrp_clear_seq.sv
module zgrp_clear_seq #(
  parameter int VL_W       = 9,
  parameter int MIN_VL_LOG = 4,
  parameter int MAX_VL_LOG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [31:0]             req_insn,
  input  logic                    req_feat_en,
  input  logic [31:0]             req_idx_val,
  input  logic [VL_W-1:0]         req_vl_bytes,
  output logic [3:0]              idx_reg_num,
  output logic                    busy,
  output logic                    clr_valid,
  input  logic                    clr_ready,
  output logic [MAX_VL_LOG-4:0]   clr_row,
  output logic                    done,
  output logic                    undef
);
  localparam int ROW_W = MAX_VL_LOG - 3;
  localparam int LOG_W = $clog2(MAX_VL_LOG + 1);

  logic             dec_ok, accept, last_fire;
  logic [1:0]       ngrp_log;
  logic [3:0]       imm;
  logic [LOG_W-1:0] stride_log;
  logic [ROW_W-1:0] sum, mask, start_row;

  zgrp_decode #(
    .VL_W(VL_W), .MIN_VL_LOG(MIN_VL_LOG), .MAX_VL_LOG(MAX_VL_LOG), .LOG_W(LOG_W)
  ) u_dec (
    .insn(req_insn), .feat_en(req_feat_en), .vl(req_vl_bytes),
    .ok(dec_ok), .ngrp_log(ngrp_log), .imm(imm),
    .stride_log(stride_log), .reg_num(idx_reg_num)
  );

  assign sum       = req_idx_val[ROW_W-1:0] + ROW_W'(imm);
  assign mask      = (ROW_W'(1) << stride_log) - ROW_W'(1);
  assign start_row = (sum & mask) & ~ROW_W'(1);

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  zgrp_rowgen #(.ROW_W(ROW_W), .LOG_W(LOG_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(accept && dec_ok),
    .start_row(start_row), .stride_log(stride_log), .ngrp_log(ngrp_log),
    .out_ready(clr_ready), .out_valid(clr_valid), .out_row(clr_row),
    .last_fire(last_fire)
  );

  assign busy = clr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      undef <= 1'b0;
    end else begin
      done  <= last_fire;
      undef <= accept && !dec_ok;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && undef)); // R10
  AST_UNDEF_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !clr_valid); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(clr_valid && clr_ready) && !clr_valid); // R10
  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_reg_num >= 4'd8 && idx_reg_num <= 4'd11); // R5
endmodule

// File: tb/zgrp_clear_seq_tb.sv
`timescale 1ns/1ps
module zgrp_clear_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_feat_en = 1'b0, clr_ready = 1'b0;
  logic [31:0] req_insn = '0, req_idx_val = '0;
  logic [8:0]  req_vl_bytes = '0;
  logic        req_ready, busy, clr_valid, done, undef;
  logic [3:0]  idx_reg_num;
  logic [4:0]  clr_row;

  always #10 clk = ~clk;

  zgrp_clear_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_insn(req_insn), .req_feat_en(req_feat_en), .req_idx_val(req_idx_val),
    .req_vl_bytes(req_vl_bytes), .idx_reg_num(idx_reg_num), .busy(busy),
    .clr_valid(clr_valid), .clr_ready(clr_ready), .clr_row(clr_row),
    .done(done), .undef(undef)
  );

  int n_chk = 0, n_bad = 0;
  int exp_rows[8];
  int exp_n;
  bit exp_bad;

  task automatic chk(bit good, string req, string what, longint act, longint expv);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] mk(int g, int rv, int off);
    return {14'b11000000000011, 1'b0, 2'(g), 2'(rv), 10'b0, 3'(off)};
  endfunction

  function automatic void model(logic [31:0] w, bit f, logic [31:0] idx, int vl);
    int g, ng, rows, stride, off, start;
    g = int'(w[16:15]);
    exp_bad = (w[31:18] != 14'b11000000000011) || w[17] || (w[12:3] != 0) ||
              (g == 0) || (g != 1 && w[2]) || !f ||
              !(vl >= 16 && vl <= 256 && (vl & (vl - 1)) == 0);
    ng     = (g == 1) ? 1 : (g == 2) ? 2 : 4;
    rows   = vl / 8;
    stride = rows / ng;
    if (stride < 2) exp_bad = 1;
    exp_n = 0;
    if (exp_bad) return;
    off   = (g == 1) ? int'(w[2:0]) * 2 : int'(w[1:0]) * 2;
    start = int'((longint'(idx) + off) % stride);
    start = start - (start % 2);
    for (int p = 0; p < ng; p++) begin
      exp_rows[exp_n]     = start + p * stride;
      exp_rows[exp_n + 1] = start + p * stride + 1;
      exp_n += 2;
    end
  endfunction

  task automatic run_req(string tag, logic [31:0] w, bit f, logic [31:0] idx, int vl);
    bit rdy, stalled;
    int k;
    model(w, f, idx, vl);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready when idle", req_ready, 1);
    req_insn = w; req_feat_en = f; req_idx_val = idx; req_vl_bytes = 9'(vl);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_bad) begin
      chk(undef && !clr_valid && !done, tag, "undef pulse, no rows",
          {undef, clr_valid, done}, 3'b100);
      @(negedge clk);
      chk(!undef && !clr_valid && !done, "R10", "undef is one cycle",
          {undef, clr_valid, done}, 0);
    end else begin
      chk(!undef, "R10", "no undef on good word", undef, 0);
      k = 0; stalled = 0;
      while (k < exp_n) begin
        chk(clr_valid && clr_row == 5'(exp_rows[k]),
            stalled ? "R9" : (k == 0 ? "R7" : tag), "row beat",
            clr_valid ? longint'(clr_row) : -1, exp_rows[k]);
        chk(!req_ready && !done, "R11", "not ready while busy", req_ready, 0);
        rdy = ($urandom_range(0, 2) != 0);
        clr_ready = rdy;
        req_valid = 1'($urandom_range(0, 1));
        req_insn  = $urandom;
        @(negedge clk);
        if (rdy) k++;
        stalled = !rdy;
      end
      clr_ready = 1'b0; req_valid = 1'b0;
      chk(done && !clr_valid && !undef, "R10", "done after last row",
          {done, clr_valid, undef}, 3'b100);
      @(negedge clk);
      chk(!done && !clr_valid, "R10", "done is one cycle", {done, clr_valid}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!clr_valid && !done && !undef && req_ready, "R10", "reset state",
        {clr_valid, done, undef, req_ready}, 1);
    rst_n = 1'b1;

    for (int rv = 0; rv < 4; rv++) begin
      req_insn = mk(1, rv, 0);
      #1;
      chk(idx_reg_num == 4'(8 + rv), "R5", "register number", idx_reg_num, 8 + rv);
    end

    for (int g = 1; g < 4; g++)
      for (int e = 0; e < 5; e++)
        run_req("R8", mk(g, 1, 3), 1'b1, 32'd5 + 32'(e), 16 << e);

    run_req("R6", mk(1, 0, 7), 1'b1, 32'd0, 256);
    run_req("R6", mk(2, 0, 3), 1'b1, 32'd0, 256);
    run_req("R7", mk(3, 2, 2), 1'b1, 32'hFFFF_FFFF, 256);
    run_req("R1", mk(1, 0, 1) ^ 32'h8000_0000, 1'b1, 32'd0, 64);
    run_req("R1", mk(1, 0, 1) | 32'h0000_0400, 1'b1, 32'd0, 64);
    run_req("R1", mk(2, 0, 1) | 32'h0002_0000, 1'b1, 32'd0, 64);
    run_req("R2", mk(0, 0, 1), 1'b1, 32'd0, 64);
    run_req("R2", mk(2, 0, 5), 1'b1, 32'd0, 64);
    run_req("R2", mk(3, 0, 4), 1'b1, 32'd0, 64);
    run_req("R3", mk(1, 0, 1), 1'b0, 32'd0, 64);
    run_req("R4", mk(1, 0, 1), 1'b1, 32'd0, 48);
    run_req("R4", mk(2, 0, 1), 1'b1, 32'd0, 16);
    run_req("R4", mk(3, 0, 1), 1'b1, 32'd0, 32);
    run_req("R4", mk(1, 0, 1), 1'b1, 32'd0, 8);

    for (int it = 0; it < 400; it++) begin
      logic [31:0] w;
      w = mk($urandom_range(1, 3), $urandom_range(0, 3), $urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
      run_req("R8", w, $urandom_range(0, 15) != 0, $urandom,
              16 << $urandom_range(0, 4));
    end
    summary();
  end
endmodule